// File: doc/BRIEF.md
# IQ Amplitude Modulator with Bypass

This block sits between the sine/cosine phase-to-amplitude tables of a digital oscillator and its output converter. Each clock it takes one signed 10-bit sine sample and one signed 10-bit cosine sample. It multiplies the cosine (in-phase) sample by an in-phase gain and the sine (quadrature) sample by a quadrature gain. It adds the two products and drives the low 10 bits of the sum as the converter code. This allows amplitude modulation, quadrature amplitude modulation and single-sideband generation.

Both gains are packed into one 20-bit modulation word. A write strobe loads the word, either directly or after a chain of retiming registers that a host uses when its strobe comes from another clock domain. When the amplitude-modulation enable is low, the raw sine sample reaches the output with the same pipeline delay as the scaled path, so switching mode never moves the sample timing.

Top module: `iq_amp_mod`

## Requirements
- R1: While `rst_n` is low, `dac_o` is 0, and reset clears the modulation word. After release with `am_en` high and no write, every output is 0 whatever the samples are.
- R2: Bits [9:0] of the modulation word are the in-phase gain, which scales `cos_i`. Bits [19:10] are the quadrature gain, which scales `sin_i`.
- R3: Samples and gains are 10-bit two's complement, and each gain is a fraction with 9 fractional bits. Each product is the full signed product shifted right arithmetically by 9, which rounds toward minus infinity.
- R4: With `am_en` high, `dac_o` is the sum of the two shifted products taken modulo 1024, as a 10-bit two's-complement code. It wraps on overflow and is never clipped.
- R5: With `am_en` low, `dac_o` equals the delayed `sin_i`. `cos_i` and both gains have no effect on the output.
- R6: Samples on the inputs at clock edge n appear on `dac_o` right after edge n+2.
- R7: `am_en` is captured together with the samples, so the mode that applies to a sample is the value present at that sample's capture edge, even when the mode toggles every cycle.
- R8: When the strobe is low, the modulation word keeps its value, and whatever is on `mod_data` has no effect on the output.
- R9: With `sync_bypass` high, a word strobed at edge k applies to the samples captured from edge k+1 onward.
- R10: With `sync_bypass` low, the strobe and the word pass through SYNC_DEPTH (default 4) retiming registers. A word strobed at edge k applies to the samples captured from edge k+1+SYNC_DEPTH onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_bypass | input | 1 | 1: a strobe loads at once; 0: the strobe goes through the retiming chain |
| mod_wr | input | 1 | Load strobe for the modulation word |
| mod_data | input | 20 | Modulation word: [19:10] quadrature gain, [9:0] in-phase gain |
| am_en | input | 1 | 1: scaled sum; 0: raw sine pass-through |
| sin_i | input | 10 | Signed sine (quadrature) sample |
| cos_i | input | 10 | Signed cosine (in-phase) sample |
| dac_o | output | 10 | Output code, two's complement |

## Verification
The bench first loads single-sided gains, with one field zero and the other at one half. This shows which sample each field scales. Next it uses minus one and one least significant bit with negative samples, which separates arithmetic truncation toward minus infinity from truncation toward zero. Full-scale negative and positive gains on full-scale samples force the sum past both ends of the range, which distinguishes wrapping from clipping. Other stimulus covers raw-path runs with nonzero gains and cosine, mode toggles every cycle, strobe-low writes of junk data, and words written in the middle of a constant-sample stream with the retiming chain both bypassed and in use. Together these pin down the exact edge at which a new word and a new mode take effect.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

  // Output path chosen for a sample; travels down the pipe with it.
  typedef enum logic {
    PATH_RAW    = 1'b0,
    PATH_SCALED = 1'b1
  } path_e;

  // Lane indices of the product array.
  localparam int LANE_IP = 0;
  localparam int LANE_QD = 1;
  localparam int N_LANES = 2;

endpackage

// File: rtl/iqm_gain_reg.sv
module iqm_gain_reg #(
  parameter  int GAIN_W     = 10,
  parameter  int SYNC_DEPTH = 4,
  localparam int REG_W      = 2 * GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_bypass,
  input  logic              ld_i,
  input  logic [REG_W-1:0]  ld_data_i,
  output logic [REG_W-1:0]  word_o,
  output logic [GAIN_W-1:0] gain_ip_o,
  output logic [GAIN_W-1:0] gain_qd_o
);

  // Retiming chain for strobe and word.
  logic [SYNC_DEPTH-1:0] line_wr_q;
  logic [SYNC_DEPTH-1:0] line_wr_d;
  logic [REG_W-1:0]      line_data_q [SYNC_DEPTH];
  logic [REG_W-1:0]      line_data_d [SYNC_DEPTH];

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_DEPTH; gs++) begin : g_line
      if (gs == 0) begin : g_head
        always_comb begin
          line_wr_d[gs]   = ld_i;
          line_data_d[gs] = ld_data_i;
        end
      end else begin : g_body
        always_comb begin
          line_wr_d[gs]   = line_wr_q[gs-1];
          line_data_d[gs] = line_data_q[gs-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_wr_q[gs]   <= 1'b0;
          line_data_q[gs] <= '0;
        end else begin
          line_wr_q[gs]   <= line_wr_d[gs];
          line_data_q[gs] <= line_data_d[gs];
        end
      end
    end
  endgenerate

  // Load source selection and the modulation word itself.
  logic             load_en;
  logic [REG_W-1:0] load_val;
  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;

  always_comb begin
    if (sync_bypass) begin
      load_en  = ld_i;
      load_val = ld_data_i;
    end else begin
      load_en  = line_wr_q[SYNC_DEPTH-1];
      load_val = line_data_q[SYNC_DEPTH-1];
    end
    word_d = load_en ? load_val : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_d;
    end
  end

  assign word_o    = word_q;
  assign gain_ip_o = word_q[GAIN_W-1:0];
  assign gain_qd_o = word_q[REG_W-1:GAIN_W];

endmodule

// File: rtl/iqm_lane.sv
module iqm_lane #(
  parameter  int W    = 10,
  localparam int FRAC = W - 1,
  localparam int PW   = 2 * W,
  localparam int OW   = W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [W-1:0]  smp_i,
  input  logic signed [W-1:0]  gain_i,
  output logic signed [OW-1:0] prod_o
);

  logic signed [PW-1:0] full;
  logic signed [OW-1:0] prod_d;
  logic signed [OW-1:0] prod_q;

  // Full signed product, then drop the fraction bits of the gain.
  always_comb begin
    full   = $signed({{W{smp_i[W-1]}}, smp_i}) * $signed({{W{gain_i[W-1]}}, gain_i});
    prod_d = OW'(full >>> FRAC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else begin
      prod_q <= prod_d;
    end
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/iqm_combine.sv
module iqm_combine
  import iqm_pkg::*;
#(
  parameter int W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  path_e             path_i,
  input  logic signed [W:0] prod_ip_i,
  input  logic signed [W:0] prod_qd_i,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      dac_o
);

  logic [W-1:0] sum_low;
  logic [W-1:0] dac_d;
  logic [W-1:0] dac_q;

  // Keep only the low W bits of the sum: overflow wraps.
  always_comb begin
    sum_low = W'(prod_ip_i + prod_qd_i);
    dac_d   = (path_i == PATH_SCALED) ? sum_low : raw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else begin
      dac_q <= dac_d;
    end
  end

  assign dac_o = dac_q;

endmodule

// File: rtl/iq_amp_mod.sv
module iq_amp_mod
  import iqm_pkg::*;
#(
  parameter  int SMP_W      = 10,
  parameter  int SYNC_DEPTH = 4,
  localparam int REG_W      = 2 * SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_bypass,
  input  logic             mod_wr,
  input  logic [REG_W-1:0] mod_data,
  input  logic             am_en,
  input  logic [SMP_W-1:0] sin_i,
  input  logic [SMP_W-1:0] cos_i,
  output logic [SMP_W-1:0] dac_o
);

  // Modulation word
  logic [REG_W-1:0] gain_word;
  logic [SMP_W-1:0] gain_ip;
  logic [SMP_W-1:0] gain_qd;

  iqm_gain_reg #(
    .GAIN_W     (SMP_W),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_gain (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_bypass (sync_bypass),
    .ld_i        (mod_wr),
    .ld_data_i   (mod_data),
    .word_o      (gain_word),
    .gain_ip_o   (gain_ip),
    .gain_qd_o   (gain_qd)
  );

  // Stage 1: capture samples, gains and mode together
  logic [SMP_W-1:0] s1_sin_q,  s1_sin_d;
  logic [SMP_W-1:0] s1_cos_q,  s1_cos_d;
  logic [SMP_W-1:0] s1_gip_q,  s1_gip_d;
  logic [SMP_W-1:0] s1_gqd_q,  s1_gqd_d;
  path_e            s1_path_q, s1_path_d;

  always_comb begin
    s1_sin_d  = sin_i;
    s1_cos_d  = cos_i;
    s1_gip_d  = gain_ip;
    s1_gqd_d  = gain_qd;
    s1_path_d = am_en ? PATH_SCALED : PATH_RAW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sin_q  <= '0;
      s1_cos_q  <= '0;
      s1_gip_q  <= '0;
      s1_gqd_q  <= '0;
      s1_path_q <= PATH_RAW;
    end else begin
      s1_sin_q  <= s1_sin_d;
      s1_cos_q  <= s1_cos_d;
      s1_gip_q  <= s1_gip_d;
      s1_gqd_q  <= s1_gqd_d;
      s1_path_q <= s1_path_d;
    end
  end

  // Stage 2: one registered multiplier per lane
  logic signed [SMP_W-1:0] lane_smp  [N_LANES];
  logic signed [SMP_W-1:0] lane_gain [N_LANES];
  logic signed [SMP_W:0]   prod_arr  [N_LANES];

  always_comb begin
    lane_smp[LANE_IP]  = $signed(s1_cos_q);
    lane_gain[LANE_IP] = $signed(s1_gip_q);
    lane_smp[LANE_QD]  = $signed(s1_sin_q);
    lane_gain[LANE_QD] = $signed(s1_gqd_q);
  end

  genvar gl;
  generate
    for (gl = 0; gl < N_LANES; gl++) begin : g_lane
      iqm_lane #(
        .W (SMP_W)
      ) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (lane_smp[gl]),
        .gain_i (lane_gain[gl]),
        .prod_o (prod_arr[gl])
      );
    end
  endgenerate

  // Stage 2 side band: raw sample and mode kept in step with the products
  logic [SMP_W-1:0] s2_raw_q,  s2_raw_d;
  path_e            s2_path_q, s2_path_d;

  always_comb begin
    s2_raw_d  = s1_sin_q;
    s2_path_d = s1_path_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_raw_q  <= '0;
      s2_path_q <= PATH_RAW;
    end else begin
      s2_raw_q  <= s2_raw_d;
      s2_path_q <= s2_path_d;
    end
  end

  // Stage 3: sum or pass-through
  iqm_combine #(
    .W (SMP_W)
  ) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .path_i    (s2_path_q),
    .prod_ip_i (prod_arr[LANE_IP]),
    .prod_qd_i (prod_arr[LANE_QD]),
    .raw_i     (s2_raw_q),
    .dac_o     (dac_o)
  );

endmodule

// File: rtl/iqm_checker.sv
module iqm_checker #(
  parameter int W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_bypass,
  input logic              mod_wr,
  input logic [2*W-1:0]    mod_data,
  input logic              am_en,
  input logic [W-1:0]      sin_i,
  input logic [W-1:0]      dac_o,
  input logic [2*W-1:0]    word_q,
  input logic signed [W:0] prod_ip,
  input logic signed [W:0] prod_qd,
  input logic              s2_scaled
);

  // Edges since reset release, saturating at 3.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 2'd1;
    end
  end

  logic rst_seen;
  always_ff @(posedge clk) begin
    rst_seen <= (rst_seen === 1'b1) || !rst_n;
  end

  logic [W-1:0] sum_low;
  assign sum_low = W'(prod_ip + prod_qd);

  always @(posedge clk) begin
    if (!rst_n && rst_seen === 1'b1) begin
      AST_RESET_ZERO: assert (dac_o == '0); // R1
    end
  end

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(am_en, 3)) |-> (dac_o == $past(sin_i, 3))); // R5

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bypass && !mod_wr) |=> $stable(word_q)); // R8

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_bypass && mod_wr) |=> (word_q == $past(mod_data))); // R9

  AST_WRAP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    s2_scaled |=> (dac_o == $past(sum_low))); // R4

endmodule

bind iq_amp_mod iqm_checker #(.W(SMP_W)) u_iqm_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_bypass (sync_bypass),
  .mod_wr      (mod_wr),
  .mod_data    (mod_data),
  .am_en       (am_en),
  .sin_i       (sin_i),
  .dac_o       (dac_o),
  .word_q      (gain_word),
  .prod_ip     (prod_arr[0]),
  .prod_qd     (prod_arr[1]),
  .s2_scaled   (s2_path_q)
);

// File: tb/tb_iq_amp_mod.sv
`timescale 1ns/100ps
module tb_iq_amp_mod;
  localparam int W  = 10;
  localparam int D  = 4;
  localparam int RW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_bypass;
  logic          mod_wr;
  logic [RW-1:0] mod_data;
  logic          am_en;
  logic [W-1:0]  sin_i;
  logic [W-1:0]  cos_i;
  logic [W-1:0]  dac_o;

  always #2.5 clk = ~clk;

  iq_amp_mod #(.SMP_W(W), .SYNC_DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .sync_bypass(sync_bypass), .mod_wr(mod_wr),
    .mod_data(mod_data), .am_en(am_en), .sin_i(sin_i), .cos_i(cos_i), .dac_o(dac_o)
  );

  typedef struct {
    int          due;
    logic [W-1:0] val;
    string       req;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int edge_cnt = 0;
  bit done = 0;

  // Reference state, built from the requirements.
  logic [RW-1:0] m_word;
  logic          m_wr   [D];
  logic [RW-1:0] m_data [D];
  logic          byp_set;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(logic [W-1:0] act, logic [W-1:0] exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] s, logic [W-1:0] c,
                                         logic [RW-1:0] g, logic en);
    int a;
    int b;
    logic [31:0] sum;
    if (!en) return s;
    a = $signed(c) * $signed(g[W-1:0]);
    b = $signed(s) * $signed(g[RW-1:W]);
    sum = (a >>> (W - 1)) + (b >>> (W - 1));
    return sum[W-1:0];
  endfunction

  // Monitor: compare each item at the cycle it is due.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == edge_cnt) begin
      check(dac_o, exp_q[0].val, exp_q[0].req);
      void'(exp_q.pop_front());
    end
  end

  // Driver: one sample per edge, expected value pushed to the scoreboard.
  task automatic step(logic [W-1:0] s, logic [W-1:0] c, logic en,
                      logic wr, logic [RW-1:0] data, string req);
    item_t it;
    @(negedge clk);
    sin_i = s; cos_i = c; am_en = en; mod_wr = wr; mod_data = data;
    sync_bypass = byp_set;
    it.due = edge_cnt + 3;
    it.val = model(s, c, m_word, en);
    it.req = req;
    exp_q.push_back(it);
    if (byp_set) begin
      if (wr) m_word = data;
    end else if (m_wr[D-1]) begin
      m_word = m_data[D-1];
    end
    for (int k = D - 1; k > 0; k--) begin
      m_wr[k]   = m_wr[k-1];
      m_data[k] = m_data[k-1];
    end
    m_wr[0]   = wr;
    m_data[0] = data;
  endtask

  task automatic run(logic [W-1:0] s, logic [W-1:0] c, logic en, int n, string req);
    for (int k = 0; k < n; k++) step(s, c, en, 1'b0, 20'h0, req);
  endtask

  task automatic load(logic [RW-1:0] g, string req);
    step(10'h0, 10'h0, 1'b1, 1'b1, g, req);
    run(10'h0, 10'h0, 1'b1, 2, req);
  endtask

  initial begin
    rst_n = 1'b0; sync_bypass = 1'b1; mod_wr = 1'b0; mod_data = '0;
    am_en = 1'b0; sin_i = '0; cos_i = '0;
    byp_set = 1'b1; m_word = '0;
    for (int k = 0; k < D; k++) begin m_wr[k] = 1'b0; m_data[k] = '0; end

    // R1: output held at zero during reset
    repeat (3) begin @(negedge clk); check(dac_o, 10'h0, "R1"); end
    @(negedge clk); rst_n = 1'b1;

    // R1: cleared word gives zero output with scaling on
    step(10'd123, 10'd77, 1'b1, 1'b0, 20'h0, "R1");
    step(10'h3FF, 10'h200, 1'b1, 1'b0, 20'h0, "R1");
    step(10'h1FF, 10'h1FF, 1'b1, 1'b0, 20'h0, "R1");

    // R5: raw path ignores gains and cosine
    step(10'd5, 10'd100, 1'b0, 1'b1, {10'h1FF, 10'h1FF}, "R5");
    for (int i = 0; i < 8; i++)
      step(10'(i * 91 + 3), 10'(i * 57), 1'b0, 1'b0, 20'h0, "R5");

    // R2: field positions
    load({10'h000, 10'h100}, "R2");
    run(10'd300, 10'd200, 1'b1, 3, "R2");
    run(10'd300, 10'h338, 1'b1, 2, "R2");
    load({10'h100, 10'h000}, "R2");
    run(10'd300, 10'd200, 1'b1, 3, "R2");

    // R3: truncation toward minus infinity
    load({10'h000, 10'h001}, "R3");
    run(10'h0, 10'h3FF, 1'b1, 2, "R3");
    run(10'h0, 10'h001, 1'b1, 2, "R3");
    run(10'h0, 10'h200, 1'b1, 2, "R3");
    load({10'h000, 10'h3FF}, "R3");
    run(10'h0, 10'd5, 1'b1, 2, "R3");

    // R4: wrap, no clipping
    load({10'h200, 10'h200}, "R4");
    run(10'h200, 10'h200, 1'b1, 2, "R4");
    run(10'h000, 10'h200, 1'b1, 2, "R4");
    load({10'h1FF, 10'h1FF}, "R4");
    run(10'h1FF, 10'h1FF, 1'b1, 2, "R4");
    run(10'h200, 10'h200, 1'b1, 2, "R4");

    // R8: data with strobe low is ignored
    for (int i = 0; i < 6; i++)
      step(10'd250, 10'd180, 1'b1, 1'b0, 20'(i * 40503 + 7), "R8");

    // R7: mode toggles every cycle
    load({10'h080, 10'h100}, "R7");
    for (int i = 0; i < 12; i++)
      step(10'(i * 61 + 9), 10'(i * 29 + 400), 1'(i % 2), 1'b0, 20'h0, "R7");

    // R6: latency across a varied stream and an impulse
    load({10'h0C0, 10'h3A0}, "R6");
    for (int i = 0; i < 40; i++)
      step(10'(i * 37), 10'(i * 53 + 11), 1'b1, 1'b0, 20'h0, "R6");
    step(10'h100, 10'h100, 1'b1, 1'b0, 20'h0, "R6");
    run(10'h0, 10'h0, 1'b1, 4, "R6");

    // R9: direct load lands on the next captured sample
    run(10'd200, 10'd150, 1'b1, 2, "R9");
    step(10'd200, 10'd150, 1'b1, 1'b1, {10'h100, 10'h040}, "R9");
    run(10'd200, 10'd150, 1'b1, 4, "R9");

    // R10: retimed load lands SYNC_DEPTH edges later
    byp_set = 1'b0;
    run(10'd200, 10'd150, 1'b1, D + 2, "R10");
    step(10'd200, 10'd150, 1'b1, 1'b1, {10'h3C0, 10'h180}, "R10");
    run(10'd200, 10'd150, 1'b1, D + 4, "R10");
    step(10'd200, 10'd150, 1'b1, 1'b1, {10'h020, 10'h1F0}, "R10");
    step(10'd200, 10'd150, 1'b1, 1'b1, {10'h050, 10'h060}, "R10");
    run(10'd200, 10'd150, 1'b1, D + 4, "R10");

    run(10'h0, 10'h0, 1'b1, 4, "R6");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 actual=%0d expected=0 pending items", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule